// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is an I2C target that behaves like a byte-addressed serial EEPROM. The storage array is an internal register memory. The block watches SCL and SDA, which it receives after a two-stage synchronizer in the `clk` domain. It detects START and STOP, matches a 7-bit device address, and then takes a two-byte memory address. It pulls SDA low through `sda_oe` to acknowledge and to send zero bits. Outside logic turns `sda_oe` into an open-drain driver.

Writes go first into a 64-byte page buffer. The buffered bytes reach the array only after STOP, during a timed programming period. While that period runs, the block stays silent on its device address, so a master can poll for completion. Reads come in three forms: current-address, random (a write header followed by a repeated START) and sequential. A `wp` input blocks all writes.

Top module: `i2c_eeprom_target`

## Requirements
- R1: The device address byte is `1010` followed by `DEV_SEL[2:0]` and the R/W bit (bit 0, where 1 means read). A match while no programming is running is acknowledged. A mismatch is not acknowledged, and every later byte is also left unacknowledged until the next START.
- R2: After a write header, the block acknowledges two address bytes: high byte first, then low byte. Only the low `MEM_AW` bits of the resulting 16-bit value select a location. All higher bits are ignored.
- R3: In a write, each accepted data byte is stored at the current address. Then only the low 6 address bits advance. Bytes beyond 64 wrap to the start of the same page and replace earlier bytes.
- R4: Buffered bytes are written to the array only after STOP. For `BUSY_CYCLES` clk cycles after that STOP, the device address gets no acknowledge. Once that time has passed, the device address is acknowledged again.
- R5: A STOP that comes before any accepted data byte does not start a programming period. The device address is acknowledged right after it.
- R6: With `wp` high, the device address and both address bytes are acknowledged. The first data byte is not acknowledged, and the array keeps its contents.
- R7: A random read is a write header with the address bytes, then a repeated START and a read header. It returns the byte stored at the given address.
- R8: In a read, a master acknowledge after a byte makes the block send the byte at the next address. A master no-acknowledge ends the transfer.
- R9: A current-address read returns the byte at the address one above the last byte read or written.
- R10: During reads, the address counter wraps from its top value (`2**MEM_AW-1`) to 0.
- R11: `sda_oe` changes only after an SCL falling edge, a START or a STOP. It never changes on its own while SCL stays high.
- R12: After reset, `sda_oe` is low, meaning SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| wp | input | 1 | 1 refuses all data bytes of writes |

## Verification
The master sees every internal state only through acknowledge slots and read data bits. A wrong state therefore shows up within one byte frame. A mis-stepped bit counter or state moves an acknowledge into the wrong slot, and the next acknowledge check catches it. A wrong page offset or wrap shows up only after STOP and a read-back: the byte values then come back at the wrong addresses. A busy timer that is too short or never started shows up on the first poll after STOP, as an acknowledge where none is due or a missing one after the wait.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
    localparam int PAGE_AW    = 6;
    localparam int PAGE_BYTES = 1 << PAGE_AW;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WDAT,
        ST_RD
    } ee_st_e;
endpackage

// File: rtl/i2c_ee_edge.sv
module i2c_ee_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev,
    output logic sda_s
);
    typedef struct packed {
        logic [1:0] scl_sync;
        logic [1:0] sda_sync;
        logic       scl_p;
        logic       sda_p;
    } edge_t;

    edge_t d, q;

    always_comb begin
        d          = q;
        d.scl_sync = {q.scl_sync[0], scl_i};
        d.sda_sync = {q.sda_sync[0], sda_i};
        d.scl_p    = q.scl_sync[1];
        d.sda_p    = q.sda_sync[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign sda_s    = q.sda_sync[1];
    assign scl_rise = q.scl_sync[1] & ~q.scl_p;
    assign scl_fall = ~q.scl_sync[1] & q.scl_p;
    assign start_ev = q.scl_sync[1] & q.scl_p & q.sda_p & ~q.sda_sync[1];
    assign stop_ev  = q.scl_sync[1] & q.scl_p & ~q.sda_p & q.sda_sync[1];
endmodule

// File: rtl/i2c_ee_array.sv
module i2c_ee_array #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/i2c_ee_pgm.sv
module i2c_ee_pgm
    import i2c_ee_pkg::*;
#(
    parameter int AW          = 11,
    parameter int BUSY_CYCLES = 5000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  buf_we,
    input  logic [PAGE_AW-1:0]    buf_off,
    input  logic [7:0]            buf_data,
    input  logic                  go,
    input  logic [AW-PAGE_AW-1:0] base_in,
    output logic                  busy,
    output logic                  mem_we,
    output logic [AW-1:0]         mem_waddr,
    output logic [7:0]            mem_wdata
);
    localparam int BUSY_EFF = (BUSY_CYCLES < PAGE_BYTES) ? PAGE_BYTES : BUSY_CYCLES;
    localparam int BCW      = $clog2(BUSY_EFF + 1);

    typedef struct packed {
        logic                            busy;
        logic [BCW-1:0]                  bcnt;
        logic [AW-PAGE_AW-1:0]           base;
        logic [PAGE_BYTES-1:0]           vld;
        logic [PAGE_BYTES-1:0][7:0]      pbuf;
    } pgm_t;

    pgm_t d, q;

    always_comb begin
        d = q;
        if (q.busy) begin
            d.bcnt = q.bcnt + 1'b1;
            if (q.bcnt == BCW'(BUSY_EFF - 1)) begin
                d.busy = 1'b0;
                d.vld  = '0;
            end
        end else begin
            if (clr) d.vld = '0;
            if (buf_we) begin
                d.pbuf[buf_off] = buf_data;
                d.vld[buf_off]  = 1'b1;
            end
            if (go && (|q.vld)) begin
                d.busy = 1'b1;
                d.bcnt = '0;
                d.base = base_in;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.busy <= 1'b0;
            q.bcnt <= '0;
            q.base <= '0;
            q.vld  <= '0;
            q.pbuf <= '0;
        end else begin
            q <= d;
        end
    end

    logic [PAGE_AW-1:0] slot;
    assign slot      = q.bcnt[PAGE_AW-1:0];
    assign busy      = q.busy;
    assign mem_we    = q.busy && (q.bcnt < BCW'(PAGE_BYTES)) && q.vld[slot];
    assign mem_waddr = {q.base, slot};
    assign mem_wdata = q.pbuf[slot];

    // R4: programming begins only on a STOP from the bus side
    assert_prog_on_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> $past(go));
    // R5: an empty buffer never starts a programming period
    assert_no_empty_prog_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> $past(|q.vld));
    // R4: the bus side never fills the buffer while programming runs
    assert_no_fill_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> !q.busy);
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
    import i2c_ee_pkg::*;
#(
    parameter int         MEM_AW      = 11,
    parameter logic [2:0] DEV_SEL     = 3'b000,
    parameter int         BUSY_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe,
    input  logic wp
);
    localparam logic [6:0] DEV_ID = {4'b1010, DEV_SEL};

    logic scl_rise, scl_fall, start_ev, stop_ev, sda_s;
    logic pgm_busy, mem_we;
    logic [MEM_AW-1:0] mem_waddr;
    logic [7:0] mem_wdata, rdata;
    logic buf_we, clr, go;

    typedef struct packed {
        ee_st_e         st;
        logic [3:0]     bitc;
        logic [7:0]     sh;
        logic [7:0]     tx;
        logic           oe;
        logic           rw;
        logic           mack;
        logic [7:0]     ahi;
        logic [MEM_AW-1:0] addr;
    } core_t;

    core_t d, q;

    i2c_ee_edge edge_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev), .sda_s(sda_s)
    );

    i2c_ee_pgm #(.AW(MEM_AW), .BUSY_CYCLES(BUSY_CYCLES)) pgm_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .buf_we(buf_we),
        .buf_off(q.addr[PAGE_AW-1:0]), .buf_data(q.sh), .go(go),
        .base_in(q.addr[MEM_AW-1:PAGE_AW]), .busy(pgm_busy),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
    );

    i2c_ee_array #(.AW(MEM_AW)) array_i (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(q.addr), .rdata(rdata)
    );

    always_comb begin
        d      = q;
        buf_we = 1'b0;
        clr    = 1'b0;
        go     = 1'b0;
        if (start_ev) begin
            d.st   = ST_DEV;
            d.bitc = 4'd0;
            d.oe   = 1'b0;
        end else if (stop_ev) begin
            d.st   = ST_IDLE;
            d.bitc = 4'd0;
            d.oe   = 1'b0;
            go     = 1'b1;
        end else if (q.st == ST_RD) begin
            if (scl_rise) begin
                if (q.bitc < 4'd8) begin
                    d.bitc = q.bitc + 4'd1;
                end else if (q.bitc == 4'd9) begin
                    d.mack = ~sda_s;
                    d.addr = q.addr + 1'b1;
                    d.bitc = 4'd10;
                end
            end else if (scl_fall) begin
                if (q.bitc == 4'd8) begin
                    d.oe   = 1'b0;
                    d.bitc = 4'd9;
                end else if (q.bitc == 4'd10) begin
                    if (q.mack) begin
                        d.tx   = rdata;
                        d.oe   = ~rdata[7];
                        d.bitc = 4'd0;
                    end else begin
                        d.st = ST_IDLE;
                    end
                end else if (q.bitc != 4'd0 && q.bitc < 4'd8) begin
                    d.oe = ~q.tx[3'(4'd7 - q.bitc)];
                end
            end
        end else if (q.st != ST_IDLE) begin
            if (scl_rise && q.bitc < 4'd8) begin
                d.sh   = {q.sh[6:0], sda_s};
                d.bitc = q.bitc + 4'd1;
            end else if (scl_fall && q.bitc == 4'd8) begin
                d.bitc = 4'd9;
                unique case (q.st)
                    ST_DEV: begin
                        if (q.sh[7:1] == DEV_ID && !pgm_busy) begin
                            d.oe = 1'b1;
                            d.rw = q.sh[0];
                            clr  = 1'b1;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                    ST_AHI: begin
                        d.oe  = 1'b1;
                        d.ahi = q.sh;
                    end
                    ST_ALO: begin
                        d.oe   = 1'b1;
                        d.addr = MEM_AW'({q.ahi, q.sh});
                    end
                    ST_WDAT: begin
                        if (!wp) begin
                            d.oe   = 1'b1;
                            buf_we = 1'b1;
                            d.addr = {q.addr[MEM_AW-1:PAGE_AW],
                                      q.addr[PAGE_AW-1:0] + 1'b1};
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                    default: d.st = ST_IDLE;
                endcase
            end else if (scl_fall && q.bitc == 4'd9) begin
                d.oe   = 1'b0;
                d.bitc = 4'd0;
                unique case (q.st)
                    ST_DEV: begin
                        if (q.rw) begin
                            d.st = ST_RD;
                            d.tx = rdata;
                            d.oe = ~rdata[7];
                        end else begin
                            d.st = ST_AHI;
                        end
                    end
                    ST_AHI:  d.st = ST_ALO;
                    ST_ALO:  d.st = ST_WDAT;
                    ST_WDAT: d.st = ST_WDAT;
                    default: d.st = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.bitc <= 4'd0;
            q.sh   <= 8'd0;
            q.tx   <= 8'd0;
            q.oe   <= 1'b0;
            q.rw   <= 1'b0;
            q.mack <= 1'b0;
            q.ahi  <= 8'd0;
            q.addr <= '0;
        end else begin
            q <= d;
        end
    end

    assign sda_oe = q.oe;

    // R11: the SDA driver only moves after an SCL fall or a bus condition
    assert_oe_timing_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.oe != $past(q.oe)) |-> $past(scl_fall || start_ev || stop_ev));
    // R4: no device address acknowledge while programming runs
    assert_busy_nack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DEV && q.bitc == 4'd8 && scl_fall && !start_ev && !stop_ev
         && pgm_busy) |=> !sda_oe);
    // R6: write protect withholds the data byte acknowledge
    assert_wp_nack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WDAT && q.bitc == 4'd8 && scl_fall && !start_ev && !stop_ev
         && wp) |=> !sda_oe);
    // R1: an idle target never drives SDA
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && !start_ev) |=> !sda_oe);
endmodule

// File: tb/i2c_eeprom_target_tb_top.sv
module i2c_eeprom_target_tb_top;
    localparam int         CLK_PERIOD = 10;
    localparam int         T          = 10;
    localparam int         BUSY       = 1500;
    localparam logic [2:0] SEL        = 3'b101;
    localparam logic [7:0] DEV_W      = {4'b1010, SEL, 1'b0};
    localparam logic [7:0] DEV_R      = {4'b1010, SEL, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_bus;
    int   n_chk = 0;
    int   n_err = 0;
    int   oe_hi_moves = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_bus = m_sda & ~sda_oe;

    i2c_eeprom_target #(.MEM_AW(11), .DEV_SEL(SEL), .BUSY_CYCLES(BUSY)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .sda_oe(sda_oe), .wp(wp)
    );

    logic oe_prev = 1'b0;
    logic scl_prev = 1'b1;
    always @(posedge clk) begin
        if (rst_n && scl && scl_prev && sda_oe != oe_prev) oe_hi_moves++;
        oe_prev  <= sda_oe;
        scl_prev <= scl;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        m_sda = 1'b1; scl = 1'b1; tw(T);
        m_sda = 1'b0; tw(T);
        scl = 1'b0; tw(T);
    endtask

    task automatic i2c_rstart();
        m_sda = 1'b1; tw(T);
        scl = 1'b1; tw(T);
        m_sda = 1'b0; tw(T);
        scl = 1'b0; tw(T);
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0; tw(T);
        scl = 1'b1; tw(T);
        m_sda = 1'b1; tw(T);
    endtask

    task automatic i2c_wr(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tw(T);
            scl = 1'b1; tw(T);
            scl = 1'b0;
        end
        m_sda = 1'b1; tw(T);
        scl = 1'b1; tw(T/2);
        ack = ~sda_bus;
        tw(T/2);
        scl = 1'b0;
    endtask

    task automatic i2c_rd(input bit mack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tw(T);
            scl = 1'b1; tw(T/2);
            b[i] = sda_bus;
            tw(T/2);
            scl = 1'b0;
        end
        m_sda = ~mack; tw(T);
        scl = 1'b1; tw(T);
        scl = 1'b0;
        m_sda = 1'b1;
    endtask

    task automatic wait_prog();
        tw(BUSY + 100);
    endtask

    task automatic header(input logic [15:0] a, input string req);
        bit ack;
        i2c_start();
        i2c_wr(DEV_W, ack); chk(ack, req, ack, 1);
        i2c_wr(a[15:8], ack); chk(ack, req, ack, 1);
        i2c_wr(a[7:0], ack);  chk(ack, req, ack, 1);
    endtask

    task automatic write_one(input logic [15:0] a, input logic [7:0] v, input string req);
        bit ack;
        header(a, req);
        i2c_wr(v, ack); chk(ack, req, ack, 1);
        i2c_stop();
        wait_prog();
    endtask

    task automatic rand_read(input logic [15:0] a, input logic [7:0] e, input string req);
        bit ack;
        logic [7:0] b;
        header(a, req);
        i2c_rstart();
        i2c_wr(DEV_R, ack); chk(ack, req, ack, 1);
        i2c_rd(1'b0, b); chk(b == e, req, b, e);
        i2c_stop();
    endtask

    // R12 reset state
    task automatic t_reset();
        tw(3);
        chk(sda_oe == 1'b0, "R12 sda released in reset", sda_oe, 0);
        rst_n = 1'b1; tw(5);
        chk(sda_oe == 1'b0, "R12 sda released after reset", sda_oe, 0);
    endtask

    // R4 byte write, busy polling, R7 random read
    task automatic t_byte_write_poll();
        bit ack;
        header(16'h0123, "R2 header ack");
        i2c_wr(8'hA5, ack); chk(ack, "R4 data ack", ack, 1);
        i2c_stop();
        i2c_start();
        i2c_wr(DEV_W, ack); chk(!ack, "R4 no ack while programming", ack, 0);
        i2c_stop();
        wait_prog();
        i2c_start();
        i2c_wr(DEV_W, ack); chk(ack, "R4 ack after programming", ack, 1);
        i2c_stop();
        rand_read(16'h0123, 8'hA5, "R7 random read");
    endtask

    // R3 page write wrap, R8 sequential read, R9 current address
    task automatic t_page_wrap();
        bit ack;
        logic [7:0] b;
        header(16'h0140, "R3 header");
        for (int i = 0; i < 66; i++) begin
            i2c_wr(8'(8'h10 + i), ack);
            if (!ack) chk(ack, "R3 page data ack", ack, 1);
        end
        i2c_stop();
        wait_prog();
        header(16'h0140, "R8 header");
        i2c_rstart();
        i2c_wr(DEV_R, ack); chk(ack, "R8 read dev ack", ack, 1);
        i2c_rd(1'b1, b); chk(b == 8'h50, "R3 wrapped byte at offset 0", b, 8'h50);
        i2c_rd(1'b1, b); chk(b == 8'h51, "R3 wrapped byte at offset 1", b, 8'h51);
        i2c_rd(1'b1, b); chk(b == 8'h12, "R8 sequential offset 2", b, 8'h12);
        i2c_rd(1'b0, b); chk(b == 8'h13, "R8 sequential offset 3", b, 8'h13);
        i2c_stop();
        i2c_start();
        i2c_wr(DEV_R, ack); chk(ack, "R9 dev ack", ack, 1);
        i2c_rd(1'b0, b); chk(b == 8'h14, "R9 current address read", b, 8'h14);
        i2c_stop();
        rand_read(16'h017F, 8'h4F, "R3 last page slot");
    endtask

    // R6 write protect
    task automatic t_wp();
        bit ack;
        wp = 1'b1;
        header(16'h0140, "R6 header ack under wp");
        i2c_wr(8'hEE, ack); chk(!ack, "R6 data nack under wp", ack, 0);
        i2c_wr(8'h77, ack); chk(!ack, "R6 later byte nack", ack, 0);
        i2c_stop();
        wait_prog();
        wp = 1'b0;
        rand_read(16'h0140, 8'h50, "R6 array unchanged");
    endtask

    // R5 stop without data
    task automatic t_empty_stop();
        bit ack;
        header(16'h0200, "R5 header");
        i2c_stop();
        i2c_start();
        i2c_wr(DEV_W, ack); chk(ack, "R5 no programming after empty write", ack, 1);
        i2c_stop();
    endtask

    // R1 address mismatch
    task automatic t_bad_addr();
        bit ack;
        i2c_start();
        i2c_wr(8'hA0, ack); chk(!ack, "R1 mismatch not acked", ack, 0);
        i2c_wr(8'h01, ack); chk(!ack, "R1 ignored until start", ack, 0);
        i2c_stop();
        i2c_start();
        i2c_wr(DEV_W, ack); chk(ack, "R1 match acked", ack, 1);
        i2c_stop();
    endtask

    // R10 wrap at top, R2 ignored high bits
    task automatic t_top_wrap();
        bit ack;
        logic [7:0] b;
        write_one(16'h07FF, 8'h3C, "R10 write top");
        write_one(16'h0000, 8'hC3, "R10 write zero");
        header(16'h07FF, "R10 header");
        i2c_rstart();
        i2c_wr(DEV_R, ack); chk(ack, "R10 dev ack", ack, 1);
        i2c_rd(1'b1, b); chk(b == 8'h3C, "R10 top byte", b, 8'h3C);
        i2c_rd(1'b0, b); chk(b == 8'hC3, "R10 wrapped to zero", b, 8'hC3);
        i2c_stop();
        rand_read(16'hC140, 8'h50, "R2 high bits ignored");
    endtask

    initial begin
        t_reset();
        t_byte_write_poll();
        t_page_wrap();
        t_wp();
        t_empty_stop();
        t_bad_addr();
        t_top_wrap();
        chk(oe_hi_moves == 0, "R11 sda_oe still while scl high", oe_hi_moves, 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule